// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block turns single requests (command, address, data write, data read) into pin activity on a NAND flash bus: the command and address latch enables, the write and read strobes, two chip-enable lines and the data bus. Every bus cycle has three parts, each measured in system clocks: a latch setup, a strobe-low phase and a strobe-high hold. Each part has its own 3-bit configuration field. Requests arrive one at a time over a valid/ready handshake. Read data comes back with a one-cycle valid pulse.

The ready/busy pin passes through a synchroniser and then an edge detector. A mode input selects which edge the detector looks for. When that edge is seen, a sticky flag is set, and an optional interrupt can be raised from it. A built-in reset sequence handles device reset without software stepping. It pulls every chip enable low, clears the flag, sends the reset command, waits for the flagged ready edge and then hands the chip enables back to their configuration bits. A global enable stops new bus cycles when it is low.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset, both strobes are high, both latch enables are low, the data bus is not driven, `rd_valid`, `rb_flag`, `irq` and `rst_busy` are low, and `req_ready` is high when `cfg_enable` is 1.
- R2: Once a request is accepted, the cycle has `cfg_setup` clocks of setup with the strobe high, then `cfg_strobe`+1 clocks with the strobe low, then `cfg_hold`+1 clocks of hold with the strobe high. When `cfg_setup` is 0 there is no setup phase. `req_ready` goes high again in the clock after the hold phase ends.
- R3: `req_op` encodes 0 = command, 1 = address, 2 = data write, 3 = data read. `nand_cle` stays high for the whole of a command cycle and `nand_ale` for the whole of an address cycle, and both stay low otherwise. Ops 0 to 2 pulse `nand_we_n`; op 3 pulses `nand_re_n`. The two strobes are never low at the same time.
- R4: For ops 0 to 2, `nand_dq_oe` is high for the whole cycle and `nand_dq_out` holds the value latched at acceptance. Command and address cycles send only `req_data[7:0]` with the upper byte at zero. A data write sends all 16 bits when `cfg_bus16` = 1 and only the low byte otherwise. During a read, `nand_dq_oe` is low.
- R5: A read captures `nand_dq_in` in the last strobe-low clock. `rd_valid` is high for exactly one clock: the first hold clock, which is the clock in which `nand_re_n` has just risen. `rd_data` has its upper byte forced to zero when `cfg_bus16` is 0.
- R6: `nand_ce_n[i]` follows `cfg_ce_n[i]` directly (0 = asserted, low) unless the reset sequence is running.
- R7: `nand_rb` is synchronised. When `cfg_rb_fall` = 0 a low-to-high edge sets `rb_flag`, and when it is 1 a high-to-low edge does. The flag rises in the third clock after the pin changes, the opposite edge leaves it unchanged, it stays set until `rb_clr` is pulsed, and `irq` = `rb_flag` AND `cfg_rb_irq_en`.
- R8: A `rst_start` pulse while the block is enabled and idle sets `rst_busy`. While busy, the sequence drives all `nand_ce_n` low, clears `rb_flag`, sends command 0xFF with `nand_cle` high, and then waits for `rb_flag` with no timeout. It then drops `rst_busy` and gives the chip enables back to `cfg_ce_n`.
- R9: While `cfg_enable` is 0, `req_ready` is low, no request is accepted, no strobe goes low, and `rst_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Global enable; 0 stops new bus cycles |
| cfg_bus16 | input | 1 | Bus width: 0 = 8-bit, 1 = 16-bit |
| cfg_setup | input | 3 | Latch setup length in clocks |
| cfg_strobe | input | 3 | Strobe-low length minus one |
| cfg_hold | input | 3 | Hold length minus one |
| cfg_ce_n | input | 2 | Chip-enable levels, 0 = assert |
| cfg_rb_fall | input | 1 | Ready/busy edge select: 0 rising, 1 falling |
| cfg_rb_irq_en | input | 1 | Interrupt enable for the edge flag |
| rb_clr | input | 1 | Pulse that clears the edge flag |
| rst_start | input | 1 | Pulse that starts the device reset sequence |
| rst_busy | output | 1 | Reset sequence in progress |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_op | input | 2 | Request kind (see R3) |
| req_data | input | 16 | Command, address or write data |
| rd_valid | output | 1 | One-clock pulse marking read data |
| rd_data | output | 16 | Read data |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 2 | Chip enables, active low |
| nand_dq_out | output | 16 | Data bus driven value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus sampled value |
| nand_rb | input | 1 | Ready/busy pin |
| rb_flag | output | 1 | Sticky edge-detect flag |
| irq | output | 1 | Interrupt |

## Verification
A wrong phase counter load or decrement changes a strobe-low or hold length by at least one clock in the same cycle. A sweep that counts the clocks of every phase for every combination of the three fields catches it. A wrong op decode or lane mask appears at once as a latch enable or data byte that differs from the value sampled during that cycle. A bad capture point moves the `rd_valid` pulse away from the rising edge of the read strobe. Detector faults move the flag's rise away from the third clock after the pin change, or let the wrong edge set it. A reset sequence that fails to clear the flag first ends before the ready pulse arrives, and does so within a few clocks of the command.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

   typedef enum logic [1:0] {
      OP_CMD  = 2'd0,
      OP_ADDR = 2'd1,
      OP_WR   = 2'd2,
      OP_RD   = 2'd3
   } nbs_op_e;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_HOLD   = 2'd3
   } nbs_phase_e;

   typedef enum logic [1:0] {
      MS_IDLE  = 2'd0,
      MS_ISSUE = 2'd1,
      MS_WAIT  = 2'd2
   } nbs_mseq_e;

endpackage

// File: rtl/nbs_rb_detect.sv
module nbs_rb_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_pin,
   input  logic fall_mode,
   input  logic clr,
   input  logic irq_en,
   output logic flag,
   output logic irq
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("nbs_rb_detect: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES:0] chain_q;

   for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_chain
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b1;
            else        chain_q[0] <= rb_pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   logic lvl_now, lvl_old, edge_hit;
   assign lvl_now  = chain_q[SYNC_STAGES-1];
   assign lvl_old  = chain_q[SYNC_STAGES];
   assign edge_hit = fall_mode ? (lvl_old & ~lvl_now) : (~lvl_old & lvl_now);

   logic flag_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (edge_hit) flag_q <= 1'b1;
      else if (clr)      flag_q <= 1'b0;
   end

   assign flag = flag_q;
   assign irq  = flag_q & irq_en;

endmodule

// File: rtl/nbs_strobe_engine.sv
module nbs_strobe_engine
   import nbs_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int TW      = 3,
   parameter bit WIDE_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wide_req,
   input  logic [TW-1:0]     t_setup,
   input  logic [TW-1:0]     t_strobe,
   input  logic [TW-1:0]     t_hold,
   input  logic              in_valid,
   output logic              in_ready,
   input  nbs_op_e           in_op,
   input  logic [DATA_W-1:0] in_data,
   output logic              busy,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic              dq_oe,
   output logic [DATA_W-1:0] dq_out,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   localparam int HALF = DATA_W / 2;
   localparam logic [TW-1:0] CNT_ONE  = TW'(1);
   localparam logic [TW-1:0] CNT_ZERO = '0;

   if ((DATA_W % 2) != 0 || DATA_W < 16) begin : g_bad_width
      $error("nbs_strobe_engine: DATA_W must be even and at least 16");
   end
   if (TW < 1 || TW > 8) begin : g_bad_tw
      $error("nbs_strobe_engine: TW must lie in 1..8");
   end

   logic wide_eff;
   if (WIDE_OK) begin : g_wide
      assign wide_eff = wide_req;
   end else begin : g_narrow
      logic unused_wide;
      assign unused_wide = wide_req;
      assign wide_eff    = 1'b0;
   end

   function automatic logic [DATA_W-1:0] lane_fit(input logic [DATA_W-1:0] v,
                                                  input logic full);
      return full ? v : {{HALF{1'b0}}, v[HALF-1:0]};
   endfunction

   nbs_phase_e        ph_q;
   nbs_op_e           op_q;
   logic [TW-1:0]     cnt_q, strobe_q, hold_q;
   logic              wide_q;
   logic [DATA_W-1:0] data_q;
   logic              rdv_q;
   logic [DATA_W-1:0] rdd_q;
   logic              accept, last_cnt;

   assign in_ready = en && (ph_q == PH_IDLE);
   assign accept   = in_valid && in_ready;
   assign last_cnt = (cnt_q == CNT_ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         op_q     <= OP_CMD;
         cnt_q    <= '0;
         strobe_q <= '0;
         hold_q   <= '0;
         wide_q   <= 1'b0;
         data_q   <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               if (accept) begin
                  op_q     <= in_op;
                  strobe_q <= t_strobe;
                  hold_q   <= t_hold;
                  wide_q   <= wide_eff;
                  data_q   <= lane_fit(in_data, wide_eff && (in_op == OP_WR));
                  if (t_setup != CNT_ZERO) begin
                     ph_q  <= PH_SETUP;
                     cnt_q <= t_setup - CNT_ONE;
                  end else begin
                     ph_q  <= PH_ACTIVE;
                     cnt_q <= t_strobe;
                  end
               end
            end
            PH_SETUP: begin
               if (last_cnt) begin
                  ph_q  <= PH_ACTIVE;
                  cnt_q <= strobe_q;
               end else begin
                  cnt_q <= cnt_q - CNT_ONE;
               end
            end
            PH_ACTIVE: begin
               if (last_cnt) begin
                  ph_q  <= PH_HOLD;
                  cnt_q <= hold_q;
               end else begin
                  cnt_q <= cnt_q - CNT_ONE;
               end
            end
            PH_HOLD: begin
               if (last_cnt) ph_q  <= PH_IDLE;
               else          cnt_q <= cnt_q - CNT_ONE;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdv_q <= 1'b0;
         rdd_q <= '0;
      end else begin
         rdv_q <= (ph_q == PH_ACTIVE) && last_cnt && (op_q == OP_RD);
         if ((ph_q == PH_ACTIVE) && last_cnt && (op_q == OP_RD))
            rdd_q <= lane_fit(dq_in, wide_q);
      end
   end

   assign busy     = (ph_q != PH_IDLE);
   assign cle      = busy && (op_q == OP_CMD);
   assign ale      = busy && (op_q == OP_ADDR);
   assign we_n     = !((ph_q == PH_ACTIVE) && (op_q != OP_RD));
   assign re_n     = !((ph_q == PH_ACTIVE) && (op_q == OP_RD));
   assign dq_oe    = busy && (op_q != OP_RD);
   assign dq_out   = data_q;
   assign rd_valid = rdv_q;
   assign rd_data  = rdd_q;

   // R9
   dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph_q == PH_IDLE) && !en) |=> (ph_q == PH_IDLE));

   // R5
   rdv_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $rose(re_n));

endmodule

// File: rtl/nbs_reset_seq.sv
module nbs_reset_seq
   import nbs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic en,
   input  logic eng_busy,
   input  logic eng_accept,
   input  logic rb_flag,
   output logic go,
   output logic busy,
   output logic ce_force,
   output logic flag_clr,
   output logic cmd_valid
);

   nbs_mseq_e st_q;

   assign go = start && en && (st_q == MS_IDLE) && !eng_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= MS_IDLE;
      end else begin
         unique case (st_q)
            MS_IDLE:  if (go) st_q <= MS_ISSUE;
            MS_ISSUE: if (eng_accept) st_q <= MS_WAIT;
            MS_WAIT:  if (!eng_busy && rb_flag) st_q <= MS_IDLE;
            default:  st_q <= MS_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != MS_IDLE);
   assign ce_force  = busy;
   assign flag_clr  = go;
   assign cmd_valid = (st_q == MS_ISSUE);

endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
   import nbs_pkg::*;
#(
   parameter int           DATA_W      = 16,
   parameter int           TW          = 3,
   parameter int           NUM_CE      = 2,
   parameter int           SYNC_STAGES = 2,
   parameter bit           WIDE_OK     = 1'b1,
   parameter logic [7:0]   RESET_CMD   = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              cfg_bus16,
   input  logic [TW-1:0]     cfg_setup,
   input  logic [TW-1:0]     cfg_strobe,
   input  logic [TW-1:0]     cfg_hold,
   input  logic [NUM_CE-1:0] cfg_ce_n,
   input  logic              cfg_rb_fall,
   input  logic              cfg_rb_irq_en,
   input  logic              rb_clr,
   input  logic              rst_start,
   output logic              rst_busy,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [DATA_W-1:0] req_data,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [NUM_CE-1:0] nand_ce_n,
   output logic [DATA_W-1:0] nand_dq_out,
   output logic              nand_dq_oe,
   input  logic [DATA_W-1:0] nand_dq_in,
   input  logic              nand_rb,
   output logic              rb_flag,
   output logic              irq
);

   localparam int HALF = DATA_W / 2;

   if (NUM_CE < 1 || NUM_CE > 8) begin : g_bad_ce
      $error("nand_bus_seq: NUM_CE must lie in 1..8");
   end
   if (HALF < 8) begin : g_bad_half
      $error("nand_bus_seq: DATA_W too narrow for the reset command");
   end

   logic              m_go, m_busy, m_ce, m_clr, m_valid;
   logic              eng_valid, eng_ready, eng_busy, eng_accept;
   nbs_op_e           eng_op;
   logic [DATA_W-1:0] eng_data;

   assign eng_valid  = m_busy ? m_valid : (req_valid && !m_go);
   assign eng_op     = m_busy ? OP_CMD  : nbs_op_e'(req_op);
   assign eng_data   = m_busy ? {{(DATA_W-8){1'b0}}, RESET_CMD} : req_data;
   assign eng_accept = eng_valid && eng_ready;
   assign req_ready  = eng_ready && !m_busy && !m_go;

   nbs_strobe_engine #(
      .DATA_W  (DATA_W),
      .TW      (TW),
      .WIDE_OK (WIDE_OK)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_enable),
      .wide_req (cfg_bus16),
      .t_setup  (cfg_setup),
      .t_strobe (cfg_strobe),
      .t_hold   (cfg_hold),
      .in_valid (eng_valid),
      .in_ready (eng_ready),
      .in_op    (eng_op),
      .in_data  (eng_data),
      .busy     (eng_busy),
      .cle      (nand_cle),
      .ale      (nand_ale),
      .we_n     (nand_we_n),
      .re_n     (nand_re_n),
      .dq_oe    (nand_dq_oe),
      .dq_out   (nand_dq_out),
      .dq_in    (nand_dq_in),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   nbs_reset_seq u_rstseq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (rst_start),
      .en         (cfg_enable),
      .eng_busy   (eng_busy),
      .eng_accept (eng_accept),
      .rb_flag    (rb_flag),
      .go         (m_go),
      .busy       (m_busy),
      .ce_force   (m_ce),
      .flag_clr   (m_clr),
      .cmd_valid  (m_valid)
   );

   nbs_rb_detect #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rbdet (
      .clk       (clk),
      .rst_n     (rst_n),
      .rb_pin    (nand_rb),
      .fall_mode (cfg_rb_fall),
      .clr       (rb_clr || m_clr),
      .irq_en    (cfg_rb_irq_en),
      .flag      (rb_flag),
      .irq       (irq)
   );

   for (genvar c = 0; c < NUM_CE; c++) begin : g_ce
      assign nand_ce_n[c] = m_ce ? 1'b0 : cfg_ce_n[c];
   end

   assign rst_busy = m_busy;

   // R3
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   // R3
   latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   // R8
   rst_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_busy && nand_cle) |-> (nand_dq_out[7:0] == RESET_CMD));

endmodule

// File: tb/nand_bus_seq_tb.sv
`timescale 1ns/1ps
module nand_bus_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b1, cfg_bus16 = 1'b0;
   logic [2:0]  cfg_setup = 3'd1, cfg_strobe = 3'd1, cfg_hold = 3'd1;
   logic [1:0]  cfg_ce_n = 2'b11;
   logic        cfg_rb_fall = 1'b0, cfg_rb_irq_en = 1'b0, rb_clr = 1'b0;
   logic        rst_start = 1'b0, rst_busy;
   logic        req_valid = 1'b0, req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [15:0] req_data = 16'h0;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [1:0]  nand_ce_n;
   logic [15:0] nand_dq_out;
   logic [15:0] nand_dq_in = 16'h0;
   logic        nand_rb = 1'b1;
   logic        rb_flag, irq;

   int total = 0;
   int fails = 0;

   always #4 clk = ~clk;

   nand_bus_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_bus16(cfg_bus16),
      .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
      .cfg_ce_n(cfg_ce_n), .cfg_rb_fall(cfg_rb_fall), .cfg_rb_irq_en(cfg_rb_irq_en),
      .rb_clr(rb_clr), .rst_start(rst_start), .rst_busy(rst_busy),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_data(req_data), .rd_valid(rd_valid), .rd_data(rd_data),
      .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
      .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n), .nand_dq_out(nand_dq_out),
      .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb),
      .rb_flag(rb_flag), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // one bus cycle with phase counting
   task automatic run_op(input int op, input logic [15:0] d, input logic [15:0] din,
                         input int ea, input int eb, input int ec, input bit w16);
      int n_set, n_low, n_hold, guard, rdv_cnt;
      bit seen_low, lat_bad, dq_bad, rd_bad;
      logic strobe, other;
      logic [15:0] exp_out, exp_rd;
      exp_out = (op == 2 && w16) ? d : {8'h00, d[7:0]};
      exp_rd  = w16 ? din : {8'h00, din[7:0]};
      @(negedge clk);
      cfg_setup = 3'(ea); cfg_strobe = 3'(eb); cfg_hold = 3'(ec); cfg_bus16 = w16;
      req_op = 2'(op); req_data = d; nand_dq_in = din; req_valid = 1'b1;
      #1;
      guard = 0;
      while (!req_ready && guard < 50) begin step(1); guard++; end
      step(1);
      req_valid = 1'b0;
      n_set = 0; n_low = 0; n_hold = 0; seen_low = 0; lat_bad = 0; dq_bad = 0;
      rd_bad = 0; rdv_cnt = 0; guard = 0;
      while (!req_ready && guard < 100) begin
         strobe = (op == 3) ? nand_re_n : nand_we_n;
         other  = (op == 3) ? nand_we_n : nand_re_n;
         if (!strobe) begin n_low++; seen_low = 1; end
         else if (!seen_low) n_set++;
         else n_hold++;
         if (nand_cle != (op == 0) || nand_ale != (op == 1) || !other) lat_bad = 1;
         if (nand_dq_oe != (op != 3)) dq_bad = 1;
         if (op != 3 && nand_dq_out != exp_out) dq_bad = 1;
         if (rd_valid) begin
            rdv_cnt++;
            if (rd_data != exp_rd || n_hold != 1) rd_bad = 1;
         end
         step(1);
         guard++;
      end
      chk(n_set == ea, "R2 setup length", n_set, ea);
      chk(n_low == eb + 1, "R2 strobe-low length", n_low, eb + 1);
      chk(n_hold == ec + 1, "R2 hold length", n_hold, ec + 1);
      chk(!lat_bad, "R3 latch enables and strobe choice", lat_bad, 0);
      chk(!dq_bad, "R4 data bus drive", dq_bad, 0);
      if (op == 3) begin
         chk(rdv_cnt == 1 && !rd_bad, "R5 read capture pulse", rdv_cnt, 1);
         chk(rd_data == exp_rd, "R5 read data value", rd_data, exp_rd);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
   end

   initial begin : main
      int bad;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1
      chk(nand_we_n && nand_re_n, "R1 strobes high", {nand_we_n, nand_re_n}, 3);
      chk(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latches and bus idle",
          {nand_cle, nand_ale, nand_dq_oe}, 0);
      chk(!rd_valid && !rb_flag && !irq && !rst_busy, "R1 status low",
          {rd_valid, rb_flag, irq, rst_busy}, 0);
      chk(req_ready, "R1 ready when enabled", req_ready, 1);

      // R2 R3 R4 R5 sweep over every timing combination
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++)
            for (int c = 0; c < 8; c++) begin
               int idx;
               idx = a * 64 + b * 8 + c;
               run_op(idx % 4, 16'(idx * 16'h0101) ^ 16'h3C5A,
                      16'(idx * 16'h0B07) ^ 16'hA5C3, a, b, c, ((idx / 4) % 2) == 1);
            end

      // R4 lane rules with fixed patterns
      run_op(2, 16'hA55A, 16'h0, 0, 0, 0, 1'b0);
      run_op(2, 16'hA55A, 16'h0, 0, 0, 0, 1'b1);
      run_op(0, 16'h1234, 16'h0, 1, 0, 0, 1'b1);
      run_op(3, 16'h0, 16'hBEEF, 0, 2, 1, 1'b0);
      run_op(3, 16'h0, 16'hBEEF, 2, 0, 0, 1'b1);

      // R6 chip enables
      for (int v = 0; v < 4; v++) begin
         @(negedge clk); cfg_ce_n = 2'(v); #1;
         chk(nand_ce_n == 2'(v), "R6 chip enable follows config", nand_ce_n, v);
      end
      @(negedge clk); cfg_ce_n = 2'b11;

      // R7 rising mode
      cfg_rb_fall = 1'b0; cfg_rb_irq_en = 1'b0;
      @(negedge clk); nand_rb = 1'b0; step(5);
      chk(!rb_flag, "R7 falling edge ignored in rising mode", rb_flag, 0);
      @(negedge clk); nand_rb = 1'b1; step(2);
      chk(!rb_flag, "R7 flag not before third clock", rb_flag, 0);
      step(1);
      chk(rb_flag, "R7 flag on third clock", rb_flag, 1);
      chk(!irq, "R7 irq masked", irq, 0);
      @(negedge clk); cfg_rb_irq_en = 1'b1; #1;
      chk(irq, "R7 irq enabled", irq, 1);
      step(4);
      chk(rb_flag, "R7 flag sticky", rb_flag, 1);
      @(negedge clk); rb_clr = 1'b1; @(negedge clk); rb_clr = 1'b0; #1;
      chk(!rb_flag && !irq, "R7 clear", {rb_flag, irq}, 0);
      // R7 falling mode
      cfg_rb_fall = 1'b1;
      @(negedge clk); nand_rb = 1'b0; step(3);
      chk(rb_flag, "R7 falling mode sets", rb_flag, 1);
      @(negedge clk); rb_clr = 1'b1; @(negedge clk); rb_clr = 1'b0;
      nand_rb = 1'b1; step(5);
      chk(!rb_flag, "R7 rising ignored in falling mode", rb_flag, 0);
      cfg_rb_fall = 1'b0; cfg_rb_irq_en = 1'b0;

      // R8 reset sequence, with a stale flag set beforehand
      @(negedge clk); nand_rb = 1'b0; step(3);
      @(negedge clk); nand_rb = 1'b1; step(5);
      chk(rb_flag, "R8 stale flag present", rb_flag, 1);
      cfg_setup = 3'd1; cfg_strobe = 3'd1; cfg_hold = 3'd1;
      @(negedge clk); rst_start = 1'b1; @(negedge clk); rst_start = 1'b0; #1;
      chk(rst_busy && nand_ce_n == 2'b00, "R8 busy and chip enables low",
          {rst_busy, nand_ce_n}, 4);
      chk(!rb_flag, "R8 flag cleared at start", rb_flag, 1'b0);
      bad = 0;
      while (!nand_cle && bad < 30) begin step(1); bad++; end
      chk(nand_cle && nand_dq_out[7:0] == 8'hFF, "R8 reset command sent",
          nand_dq_out[7:0], 255);
      bad = 0;
      while (nand_cle && bad < 30) begin step(1); bad++; end
      step(10);
      chk(rst_busy && nand_ce_n == 2'b00, "R8 waits for ready edge",
          {rst_busy, nand_ce_n}, 4);
      @(negedge clk); nand_rb = 1'b0; step(4);
      @(negedge clk); nand_rb = 1'b1;
      bad = 0;
      step(1);
      while (rst_busy && bad < 20) begin step(1); bad++; end
      chk(!rst_busy, "R8 finishes after ready edge", rst_busy, 0);
      chk(nand_ce_n == 2'b11, "R8 chip enables released", nand_ce_n, 3);

      // R9 disable
      @(negedge clk); cfg_enable = 1'b0; req_op = 2'd2; req_valid = 1'b1;
      rst_start = 1'b1;
      bad = 0;
      for (int k = 0; k < 20; k++) begin
         step(1);
         if (req_ready || !nand_we_n || !nand_re_n || rst_busy) bad++;
      end
      chk(bad == 0, "R9 no activity while disabled", bad, 0);
      @(negedge clk); req_valid = 1'b0; rst_start = 1'b0; cfg_enable = 1'b1; #1;
      chk(req_ready && !rst_busy, "R9 ready after re-enable", req_ready, 1);

      summary();
      $finish;
   end

endmodule